// File: doc/BRIEF.md
# Two-Current State-Feedback Regulator

This block is the current loop of a grid-tied voltage source inverter that sits behind an inductor–capacitor–inductor filter. On each control tick, normally every 20 µs, a start strobe captures four signed samples: the reference and the measured value of the grid-side inductor current, and the same pair for the inverter-side inductor current. The block forms the two tracking errors, weights each by a fixed optimal-feedback gain and adds the results. It rounds and saturates the sum into a normalized switching-function command for a downstream PWM modulator, and marks that command with a one-cycle valid pulse.

The feedback law covers three states, ordered as grid-side current, filter-capacitor voltage and inverter-side current. The capacitor-voltage gain is fixed at zero, so that voltage is neither sensed nor multiplied, and the block has no input for it. The default gains are 20277 and 3044 in Q1.15, which stand for 0.6188 and 0.0929. Pulling the enable low or asserting reset drives the command to zero and discards any computation in flight.

Top module: `lqr_current_reg`

## Requirements
- R1: During and after synchronous reset, `cmd` is 0 and `cmd_valid` is 0 until a new result is produced.
- R2: Errors are `ref - meas` per current, taken from the inputs in the cycle where `start` is high with `en` high; input changes in later cycles do not alter that result.
- R3: The result is `(20277*e_grid + 3044*e_inv)` with all values in Q1.15 two's complement (bit 15 is the sign, 1.0 = 32768), scaled back by 2^15; no capacitor-voltage term contributes.
- R4: A result above 32767 is clamped to 32767 and one below -32768 is clamped to -32768.
- R5: Scaling rounds half upward: the block adds 2^14 to the sum and then takes the floor of the division by 2^15, so -0.6188 becomes -1 and +0.6188 becomes +1.
- R6: `cmd_valid` is high for exactly the one cycle that is three cycles after each accepted `start`, and `cmd` carries the new value in that cycle; starts on consecutive cycles each produce their own pulse.
- R7: While `en` is low, `cmd` is 0, `cmd_valid` is 0, `start` is ignored, and results already in flight are dropped.
- R8: Between valid pulses, with `en` high, `cmd` holds the last result.
- R9: When both references equal their measurements, including an all-zero reference, the result is exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable; low forces the output to zero |
| start | input | 1 | Control-tick strobe that captures the samples |
| i_grid_ref | input | 16 | Grid-side current reference, Q1.15 |
| i_grid_meas | input | 16 | Grid-side current measurement, Q1.15 |
| i_inv_ref | input | 16 | Inverter-side current reference, Q1.15 |
| i_inv_meas | input | 16 | Inverter-side current measurement, Q1.15 |
| cmd | output | 16 | Switching-function command, Q1.15, range [-1, +1) |
| cmd_valid | output | 1 | One-cycle pulse marking a new command |

## Verification
The hardest case to reach from the ports is an enable drop while a sample is part way through the three-stage pipeline. A result that survives it would show up as a stray valid pulse after the enable returns. The stimulus removes the enable one and two cycles after a start, and also asserts start while the enable is low. It then keeps the enable high and compares every cycle against a behavioural queue model. Rounding and clamping are reached with single-count errors of either sign and with full-scale errors in both directions.

// File: rtl/lqr_pkg.sv
package lqr_pkg;

    parameter int CUR_W  = 16;              // Q1.15 sample and command width
    parameter int FRAC   = 15;              // fractional bits of samples and gains
    parameter int GAIN_W = 16;              // Q1.15 gain width
    parameter int NSENSE = 2;               // sensed states (capacitor voltage gain is zero)

    localparam int ERR_W  = CUR_W + 1;
    localparam int PROD_W = ERR_W + GAIN_W;
    localparam int ACC_W  = PROD_W + $clog2(NSENSE) + 1;

    // sensed-state slots, in state-vector order with the capacitor state skipped
    localparam int SL_GRID = 0;
    localparam int SL_INV  = 1;

    typedef logic signed [CUR_W-1:0]  cur_t;
    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic                           vld;
        logic [NSENSE-1:0][ERR_W-1:0]   e;
    } err_bus_t;

    typedef struct packed {
        logic                           vld;
        logic [NSENSE-1:0][PROD_W-1:0]  p;
    } prod_bus_t;

    localparam acc_t SAT_HI = acc_t'((64'sd1 <<< (CUR_W-1)) - 1);
    localparam acc_t SAT_LO = -SAT_HI - acc_t'(1);
    localparam acc_t HALF   = acc_t'(64'sd1 <<< (FRAC-1));

    // round half up, then clamp into the command range
    function automatic cur_t round_sat(input acc_t a);
        acc_t t;
        t = (a + HALF) >>> FRAC;
        if (t > SAT_HI)      return cur_t'(SAT_HI);
        else if (t < SAT_LO) return cur_t'(SAT_LO);
        else                 return cur_t'(t);
    endfunction

endpackage

// File: rtl/lqr_err_stage.sv
module lqr_err_stage
    import lqr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 start,
    input  logic [NSENSE-1:0][CUR_W-1:0] ref_v,
    input  logic [NSENSE-1:0][CUR_W-1:0] meas_v,
    output err_bus_t             err_q
);

    always_ff @(posedge clk) begin
        if (rst || !en) err_q.vld <= 1'b0;
        else            err_q.vld <= start;
    end

    for (genvar s = 0; s < NSENSE; s++) begin : g_err
        err_t diff;
        assign diff = err_t'($signed(ref_v[s])) - err_t'($signed(meas_v[s]));
        always_ff @(posedge clk) begin
            if (rst)                err_q.e[s] <= '0;
            else if (en && start)   err_q.e[s] <= diff;
        end
    end

endmodule

// File: rtl/lqr_mac.sv
module lqr_mac
    import lqr_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               en,
    input  logic [NSENSE-1:0][GAIN_W-1:0]      gains,
    input  err_bus_t                           err_d,
    output prod_bus_t                          prod_q
);

    always_ff @(posedge clk) begin
        if (rst || !en) prod_q.vld <= 1'b0;
        else            prod_q.vld <= err_d.vld;
    end

    for (genvar s = 0; s < NSENSE; s++) begin : g_mul
        prod_t pr;
        assign pr = prod_t'($signed(err_d.e[s])) * prod_t'($signed(gains[s]));
        always_ff @(posedge clk) begin
            if (rst)                   prod_q.p[s] <= '0;
            else if (en && err_d.vld)  prod_q.p[s] <= pr;
        end
    end

endmodule

// File: rtl/lqr_out_stage.sv
module lqr_out_stage
    import lqr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  prod_bus_t  prod_d,
    output cur_t       cmd_q,
    output logic       vld_q
);

    acc_t sum;
    cur_t sat;

    always_comb begin
        sum = '0;
        for (int s = 0; s < NSENSE; s++)
            sum = sum + acc_t'($signed(prod_d.p[s]));
        sat = round_sat(sum);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cmd_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= prod_d.vld;
            if (prod_d.vld) cmd_q <= sat;
        end
    end

    // R4: a sum beyond the range lands on the matching rail
    p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        (en && prod_d.vld && ((sum + HALF) >>> FRAC) > SAT_HI) |=> (cmd_q == cur_t'(SAT_HI)));

endmodule

// File: rtl/lqr_current_reg.sv
module lqr_current_reg
    import lqr_pkg::*;
#(
    parameter int K_GRID = 20277,   // 0.6188 in Q1.15
    parameter int K_INV  = 3044     // 0.0929 in Q1.15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    start,
    input  logic signed [CUR_W-1:0] i_grid_ref,
    input  logic signed [CUR_W-1:0] i_grid_meas,
    input  logic signed [CUR_W-1:0] i_inv_ref,
    input  logic signed [CUR_W-1:0] i_inv_meas,
    output logic signed [CUR_W-1:0] cmd,
    output logic                    cmd_valid
);

    logic [NSENSE-1:0][CUR_W-1:0]  ref_v, meas_v;
    logic [NSENSE-1:0][GAIN_W-1:0] gains;
    err_bus_t  err_b;
    prod_bus_t prod_b;
    cur_t      cmd_i;

    assign ref_v[SL_GRID]  = i_grid_ref;
    assign ref_v[SL_INV]   = i_inv_ref;
    assign meas_v[SL_GRID] = i_grid_meas;
    assign meas_v[SL_INV]  = i_inv_meas;
    assign gains[SL_GRID]  = GAIN_W'(K_GRID);
    assign gains[SL_INV]   = GAIN_W'(K_INV);

    lqr_err_stage u_err (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .ref_v(ref_v), .meas_v(meas_v), .err_q(err_b)
    );

    lqr_mac u_mac (
        .clk(clk), .rst(rst), .en(en), .gains(gains),
        .err_d(err_b), .prod_q(prod_b)
    );

    lqr_out_stage u_out (
        .clk(clk), .rst(rst), .en(en), .prod_d(prod_b),
        .cmd_q(cmd_i), .vld_q(cmd_valid)
    );

    assign cmd = cmd_i;

    // R6: a valid pulse only follows an accepted start three cycles back
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(start, 3) && $past(en, 3)));

    // R7: a low enable clears the outputs at the next edge
    p_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cmd == '0 && !cmd_valid));

    // R8: the command holds between updates
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && en && $past(en) && !$past(rst)) |-> $stable(cmd));

    // R9: matching references and measurements give a zero command
    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(start && i_grid_ref == i_grid_meas
                                  && i_inv_ref == i_inv_meas, 3)) |-> (cmd == '0));

endmodule

// File: tb/tb_lqr_current_reg.sv
module tb_lqr_current_reg;

    logic clk = 1'b0;
    logic rst, en, start;
    logic signed [15:0] gr, gm, ir, im;
    logic signed [15:0] cmd;
    logic cmd_valid;

    int total = 0, bad = 0;
    string tag = "R1";
    int exp_cmd = 0;
    bit exp_v = 1'b0;
    int pv[$] = '{0, 0};
    int pc[$] = '{0, 0};
    int seed = 32'h1d2c3b4a;

    always #10 clk = ~clk;   // 50 MHz

    lqr_current_reg dut (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .i_grid_ref(gr), .i_grid_meas(gm), .i_inv_ref(ir), .i_inv_meas(im),
        .cmd(cmd), .cmd_valid(cmd_valid)
    );

    function automatic int model_cmd(int a, int b, int c, int d);
        longint s, r;
        s = 64'sd20277 * longint'(a - b) + 64'sd3044 * longint'(c - d);
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int rnd16();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return int'($signed(seed[15:0]));
    endfunction

    task automatic tick(input bit s);
        start = s;
        @(posedge clk);
        if (rst || !en) begin
            exp_cmd = 0; exp_v = 1'b0;
            pv = '{0, 0}; pc = '{0, 0};
        end else begin
            exp_v = (pv[1] != 0);
            if (exp_v) exp_cmd = pc[1];
            pv = '{int'(s), pv[0]};
            pc = '{model_cmd(gr, gm, ir, im), pc[0]};
        end
        @(negedge clk);
        total++;
        if (cmd !== 16'(exp_cmd) || cmd_valid !== exp_v) begin
            bad++;
            $display("FAIL %s: cmd=%0d valid=%0b expected cmd=%0d valid=%0b",
                     tag, cmd, cmd_valid, exp_cmd, exp_v);
        end
    endtask

    task automatic set_in(input int a, input int b, input int c, input int d);
        gr = 16'(a); gm = 16'(b); ir = 16'(c); im = 16'(d);
    endtask

    task automatic one_shot(input int a, input int b, input int c, input int d);
        set_in(a, b, c, d);
        tick(1);
        repeat (4) tick(0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b1; start = 1'b0;
        set_in(100, 0, 200, 0);
        @(negedge clk);
        tag = "R1"; tick(1); tick(1); tick(0);
        rst = 1'b0;
        tick(0); tick(0);

        tag = "R3";
        one_shot(8000, 2000, 0, 1000);
        one_shot(-5000, 3000, 7000, -2000);
        one_shot(1234, -4321, -800, 800);
        for (int k = 0; k < 20; k++) one_shot(rnd16() / 2, rnd16() / 2, rnd16() / 2, rnd16() / 2);

        tag = "R4";
        one_shot(32767, -32768, 32767, -32768);
        one_shot(-32768, 32767, -32768, 32767);
        one_shot(30000, -30000, 0, 0);

        tag = "R5";
        one_shot(1, 0, 0, 0);
        one_shot(0, 1, 0, 0);
        one_shot(0, 0, 5, 0);
        one_shot(0, 0, 0, 6);

        tag = "R6";
        for (int k = 0; k < 5; k++) begin
            set_in(1000 * k, -500, 300 * k, 100);
            tick(1);
        end
        repeat (4) tick(0);

        tag = "R2";
        set_in(6000, 1000, -2000, 500);
        tick(1);
        set_in(-9000, 9000, 9000, -9000);
        repeat (4) tick(0);

        tag = "R7";
        set_in(4000, 0, 4000, 0);
        tick(1);
        en = 1'b0; tick(0);
        en = 1'b1; repeat (4) tick(0);
        set_in(-7000, 0, 0, 0);
        tick(1); tick(0);
        en = 1'b0; tick(0);
        en = 1'b1; repeat (4) tick(0);
        one_shot(2500, 0, 0, 0);
        en = 1'b0; set_in(9000, 0, 0, 0);
        tick(1); tick(1);
        en = 1'b1; repeat (4) tick(0);

        tag = "R8";
        one_shot(3000, -3000, 1500, 0);
        for (int k = 0; k < 8; k++) begin
            set_in(rnd16(), rnd16(), rnd16(), rnd16());
            tick(0);
        end

        tag = "R9";
        one_shot(5000, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            int a, b;
            a = rnd16(); b = rnd16();
            one_shot(a, a, b, b);
        end
        for (int k = 0; k < 10; k++) one_shot(0, 0, 0, 0);

        tag = "R6";
        for (int k = 0; k < 400; k++) begin
            set_in(rnd16(), rnd16(), rnd16(), rnd16());
            en = ((rnd16() & 15) != 0);
            tick((rnd16() & 3) == 0);
        end
        en = 1'b1;
        repeat (4) tick(0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule